// File: doc/BRIEF.md
# Dual LED Pin Driver

This block drives two LED pins from a small set of configuration inputs. The two pins can feed two separate LEDs, each to ground or each to the standby rail. They can also feed one bi-colour LED wired across both pins. A single wiring bit picks the arrangement, and a polarity bit picks which pin level lights the LED. In the bi-colour arrangement, the polarity bit picks which way current flows.

Each pin has a two-bit selector that asks for off, steady on, a slow blink or a fast blink. Both blink rates come from one shared timebase that divides the reference clock. A mode bit hands control to the current power state, which arrives as a two-bit code. In that mode a fixed table sets both pins: working gives steady on, sleep gives slow blink, and soft-off gives off.

Top module: `dual_led_driver`

## Requirements
- R1: While rst_ni is low, both led_a_o and led_b_o are 0.
- R2: Selector code 2'b00 requests off and 2'b01 requests steady on, at every blink phase.
- R3: Selector code 2'b10 is a slow blink. The timebase ticks once every TICK_DIV clocks and a 3-bit phase counts the ticks. The request is on while the phase is 0..3 and off while it is 4..7, which gives an 8-tick period. Both the tick divider and the phase start at zero after reset.
- R4: Selector code 2'b11 is a fast blink. The request is on while the phase is even and off while it is odd, which gives a 2-tick period.
- R5: With indep_i=1 and pol_i=0, each pin follows its own selector and is high when its request is on.
- R6: With indep_i=1 and pol_i=1, each pin follows its own selector and is low when its request is on.
- R7: With indep_i=0 and pol_i=0, an on request from pin A alone drives {a,b}=2'b10, and an on request from pin B alone drives {a,b}=2'b01.
- R8: With indep_i=0 and pol_i=1, an on request from pin A alone drives {a,b}=2'b01, and an on request from pin B alone drives {a,b}=2'b10.
- R9: With indep_i=0, on requests from both pins at the same time drive {a,b}=2'b10 for either polarity.
- R10: With indep_i=0, when neither pin requests on, both pins are driven low.
- R11: With auto_i=1 the selectors are ignored and both requests come from pwr_i. Code 2'b00 (working) gives steady on, 2'b01 (sleep) gives slow blink, and 2'b10 or 2'b11 (soft-off) gives off.
- R12: The pins are registered. Their value after a rising edge is set by the inputs and the blink phase in effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| indep_i | input | 1 | 1: two separate LEDs, 0: one bi-colour LED across both pins |
| pol_i | input | 1 | On-level / current direction select |
| sel_a_i | input | 2 | Pin A selector: 00 off, 01 on, 10 slow, 11 fast |
| sel_b_i | input | 2 | Pin B selector: 00 off, 01 on, 10 slow, 11 fast |
| auto_i | input | 1 | 1: requests follow the power state table |
| pwr_i | input | 2 | Power state: 00 working, 01 sleep, 1x soft-off |
| led_a_o | output | 1 | Pin A level |
| led_b_o | output | 1 | Pin B level |

## Verification
Every pin result is due on the rising edge that samples the inputs, and it can be seen from the falling edge that follows. The driver writes the inputs on a falling edge. It records the index of the next rising edge and stores the expected pins for that edge. It works out the blink phase of that edge from the edge count since reset, as floor(index/TICK_DIV) mod 8. The monitor compares an entry only after the bench's own edge counter has passed the recorded index, so each comparison lands half a cycle after the edge that produced it. Each setting is held for 40 cycles, which is longer than one full slow period at the bench divider. This makes every blink transition fall inside the compared window.

// File: rtl/dled_pkg.sv
package dled_pkg;
  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_ON   = 2'b01,
    SEL_SLOW = 2'b10,
    SEL_FAST = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PWR_WORK  = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_OFF0  = 2'b10,
    PWR_OFF1  = 2'b11
  } pwr_e;

  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PH_W     = 3;
endpackage

// File: rtl/dled_timebase.sv
module dled_timebase #(
  parameter int unsigned TICK_DIV = 4_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slow_o,
  output logic fast_o
);
  import dled_pkg::*;

  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0]   pre_q;
  logic [PH_W-1:0] ph_q;
  logic            tick;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      ph_q  <= ph_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // first half of each period is "on"
  assign slow_o = ~ph_q[PH_W-1];
  assign fast_o = ~ph_q[0];

  // R3
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick) |-> $stable(ph_q));

  // R4
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ph_q) |-> ph_q == PH_W'($past(ph_q) + 1'b1));
endmodule

// File: rtl/dled_request.sv
module dled_request
  import dled_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0][1:0]  sel_i,
  input  logic                      auto_i,
  input  logic [1:0]                pwr_i,
  input  logic                      slow_i,
  input  logic                      fast_i,
  output logic [NUM_PINS-1:0]       on_o
);
  sel_e auto_sel;

  always_comb begin
    unique case (pwr_e'(pwr_i))
      PWR_WORK:  auto_sel = SEL_ON;
      PWR_SLEEP: auto_sel = SEL_SLOW;
      default:   auto_sel = SEL_OFF;
    endcase
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sel_e eff;
    assign eff = auto_i ? auto_sel : sel_e'(sel_i[p]);
    always_comb begin
      unique case (eff)
        SEL_OFF:  on_o[p] = 1'b0;
        SEL_ON:   on_o[p] = 1'b1;
        SEL_SLOW: on_o[p] = slow_i;
        default:  on_o[p] = fast_i;
      endcase
    end
  end

  // R11
  auto_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && pwr_i[1]) |-> (on_o == '0));
endmodule

// File: rtl/dled_pin_map.sv
module dled_pin_map
  import dled_pkg::*;
(
  input  logic                indep_i,
  input  logic                pol_i,
  input  logic [NUM_PINS-1:0] on_i,
  output logic [NUM_PINS-1:0] pins_o   // [1]=pin A, [0]=pin B
);
  always_comb begin
    if (indep_i) begin
      pins_o = {on_i[0] ^ pol_i, on_i[1] ^ pol_i};
    end else begin
      unique case (on_i)
        2'b11:   pins_o = 2'b10;                   // fixed colour on conflict
        2'b01:   pins_o = pol_i ? 2'b01 : 2'b10;   // A alone
        2'b10:   pins_o = pol_i ? 2'b10 : 2'b01;   // B alone
        default: pins_o = 2'b00;                   // no current
      endcase
    end
  end
endmodule

// File: rtl/dual_led_driver.sv
module dual_led_driver
  import dled_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       indep_i,
  input  logic       pol_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  input  logic       auto_i,
  input  logic [1:0] pwr_i,
  output logic       led_a_o,
  output logic       led_b_o
);
  logic                slow, fast;
  logic [NUM_PINS-1:0] on;      // [0]=A, [1]=B
  logic [NUM_PINS-1:0] pins_d;
  logic [NUM_PINS-1:0] pins_q;

  dled_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slow_o(slow),
    .fast_o(fast)
  );

  dled_request u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i ({sel_b_i, sel_a_i}),
    .auto_i(auto_i),
    .pwr_i (pwr_i),
    .slow_i(slow),
    .fast_i(fast),
    .on_o  (on)
  );

  dled_pin_map u_map (
    .indep_i(indep_i),
    .pol_i  (pol_i),
    .on_i   (on),
    .pins_o (pins_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else         pins_q <= pins_d;
  end

  assign led_a_o = pins_q[1];
  assign led_b_o = pins_q[0];

  // R10
  bicolour_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(indep_i) && $past(on) == '0) |-> (!led_a_o && !led_b_o));

  // R7
  bicolour_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(indep_i) && $past(on) != '0) |-> (led_a_o != led_b_o));

  // R9
  bicolour_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(indep_i) && $past(on) == 2'b11) |-> (led_a_o && !led_b_o));

  // R5
  indep_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(indep_i)) |-> (led_a_o == ($past(on[0]) ^ $past(pol_i))));
endmodule

// File: tb/dual_led_driver_test.sv
module dual_led_driver_test;
  localparam int TD = 4;
  localparam int HOLD = 40;

  typedef struct {
    int         due;
    logic [1:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       indep = 1'b0, pol = 1'b0, au = 1'b0;
  logic [1:0] sa = 2'b00, sb = 2'b00, pw = 2'b00;
  logic       led_a, led_b;

  int    edges_seen = 0;
  int    n_chk = 0, n_bad = 0;
  item_t sb_q[$];
  bit    done = 1'b0;

  always #5 clk = ~clk;

  dual_led_driver #(.TICK_DIV(TD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .indep_i(indep), .pol_i(pol),
    .sel_a_i(sa), .sel_b_i(sb), .auto_i(au), .pwr_i(pw),
    .led_a_o(led_a), .led_b_o(led_b)
  );

  always @(posedge clk) if (rst_n) edges_seen <= edges_seen + 1;

  function automatic logic req(input logic [1:0] s, input int e);
    int ph;
    ph = (e / TD) % 8;
    case (s)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return ph < 4;      // R3
      default: return (ph % 2) == 0; // R4
    endcase
  endfunction

  function automatic logic [1:0] model(input logic i, p, input logic [1:0] a, b,
                                       input logic m, input logic [1:0] w, input int e);
    logic [1:0] ea, eb;
    logic ra, rb;
    if (m) begin // R11
      ea = (w == 2'b00) ? 2'b01 : (w == 2'b01) ? 2'b10 : 2'b00;
      eb = ea;
    end else begin
      ea = a; eb = b;
    end
    ra = req(ea, e);
    rb = req(eb, e);
    if (i) return {ra ^ p, rb ^ p};
    if (ra && rb) return 2'b10;
    if (ra) return p ? 2'b01 : 2'b10;
    if (rb) return p ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  task automatic apply(input logic i, p, input logic [1:0] a, b,
                       input logic m, input logic [1:0] w, input string tag);
    for (int k = 0; k < HOLD; k++) begin
      item_t it;
      @(negedge clk);
      indep = i; pol = p; sa = a; sb = b; au = m; pw = w;
      it.due = edges_seen;
      it.exp = model(i, p, a, b, m, w, edges_seen);
      it.tag = tag;
      sb_q.push_back(it);
    end
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due < edges_seen) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if ({led_a, led_b} !== it.exp) begin
        n_bad++;
        $display("FAIL %s edge %0d: pins=%b expected=%b", it.tag, it.due, {led_a, led_b}, it.exp);
      end
    end
  end

  initial begin
    // R1: inputs that would light pins if not held in reset
    indep = 1'b1; pol = 1'b1; sa = 2'b00; sb = 2'b00;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({led_a, led_b} !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 reset: pins=%b expected=00", {led_a, led_b});
    end
    rst_n = 1'b1;

    // R12: latency check via steady on/off changes
    apply(1, 0, 2'b01, 2'b00, 0, 2'b00, "R12");
    apply(1, 0, 2'b00, 2'b01, 0, 2'b00, "R12");
    // R2 steady codes, R3 slow, R4 fast
    apply(1, 0, 2'b01, 2'b00, 0, 2'b00, "R2");
    apply(1, 0, 2'b10, 2'b10, 0, 2'b00, "R3");
    apply(1, 0, 2'b11, 2'b10, 0, 2'b00, "R4");

    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            string t;
            if (c == 1) t = (p == 0) ? "R5" : "R6";
            else if (a == 1 && b == 1) t = "R9";
            else if (a == 0 && b == 0) t = "R10";
            else t = (p == 0) ? "R7" : "R8";
            apply(c[0], p[0], a[1:0], b[1:0], 0, 2'b00, t);
          end

    // R11: selectors set to something that would differ
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 4; w++)
          apply(c[0], p[0], 2'b11, 2'b01, 1, w[1:0], "R11");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: pins=%b expected=completion", {led_a, led_b});
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule